// File: doc/BRIEF.md
# Debug power-up request controller

This controller sits inside a core's debug unit, between the debugger's 32-bit register port and the power management controller of the core's power domain. A debugger write to the power-control register drives two level outputs toward the power controller. One asks for the domain to be powered up. The other asks that the domain stay powered, so that a later powerdown request from the core is only emulated. A read-only status register shows the live power acknowledge and the live double-lock state of the core.

The same two status conditions produce an access-permitted signal. This signal gates every other debug register behind the controller. A protected access is forwarded to the downstream register file only while the domain is powered and the double lock is clear. Otherwise the controller answers the access itself with zero data and a one-cycle error flag. The downstream file takes address and write data from the shared bus. The power controller's own sequencing is outside this block.

Top module: `dbg_pwr_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both request outputs are 0, the read data is 0 and the error flag is 0.
- R2: A write to the power-control register (byte offset 0x310) loads bit 3 into the power-up request output and bit 0 into the no-powerdown request output. The outputs change on the clock edge that takes the write. A 0 clears the output, and without such a write both outputs hold.
- R3: A read of the power-control register returns the power-up request in bit 3 and the no-powerdown request in bit 0, with all other bits 0.
- R4: A read of the status register (byte offset 0x314) returns the power acknowledge input in bit 0 and the double-lock input in bit 6, both as sampled in the request cycle, with all other bits 0. The status never holds a stale powered-up value after the acknowledge drops.
- R5: The access-permitted output is 1 exactly when the power acknowledge is 1 and the double lock is 0.
- R6: An access to any other offset while access is permitted raises the downstream select in the same cycle, with the write strobe equal to the request's write flag. The next cycle returns the downstream read data sampled in the request cycle for a read, or 0 for a write, with the error flag 0.
- R7: An access to any other offset while access is not permitted keeps the downstream select low. The next cycle returns 0 with the error flag 1 for that one cycle.
- R8: Writes to the status register change nothing: the double-lock bit and the request outputs keep their values, and the response is 0 with no error.
- R9: A powerdown request from the core is passed on as powerdown-allowed when the no-powerdown output is 0. It is flagged as emulated instead, leaving the domain on, when the no-powerdown output is 1.
- R10: The power-control and status registers are served, without error, whether or not access is permitted.
- R11: Every response (read data and error flag) appears in the cycle after the request. A cycle without a request returns 0 and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the request |
| err_o | output | 1 | Error response, the cycle after a denied access |
| prot_sel_o | output | 1 | Select toward the protected register file |
| prot_we_o | output | 1 | Write strobe toward the protected register file |
| prot_rdata_i | input | 32 | Read data from the protected register file |
| pwrup_req_o | output | 1 | Power-up request to the power controller |
| nopd_req_o | output | 1 | No-powerdown request to the power controller |
| pwr_ack_i | input | 1 | Power controller acknowledge: domain is powered |
| dlk_i | input | 1 | Double-lock state from the core |
| core_pd_req_i | input | 1 | Powerdown request from the core |
| pd_allow_o | output | 1 | Powerdown may proceed |
| pd_emul_o | output | 1 | Powerdown is emulated, domain stays on |
| acc_ok_o | output | 1 | Protected debug access permitted |

## Verification
A wrong request bit appears within one cycle on the request outputs and on the powerdown-allowed and emulated outputs. The next control-register read shows it too. A wrong permission decision shows in the same cycle on the downstream select. The response the following cycle then carries a missing or spurious error flag. A status path that latches instead of following the acknowledge shows up on the first status read after the acknowledge falls. The bench model predicts every output on every cycle, so any of these faults fails within one to two cycles of the stimulus that exposes it.

// File: rtl/dbg_pwr_pkg.sv
package dbg_pwr_pkg;
  typedef enum logic [1:0] {
    RGN_CTRL = 2'd0,
    RGN_STAT = 2'd1,
    RGN_PROT = 2'd2
  } rgn_e;

  // bit positions decoded by the power controller and the debugger
  localparam int unsigned PUR_BIT = 3;
  localparam int unsigned NPD_BIT = 0;
  localparam int unsigned PU_BIT  = 0;
  localparam int unsigned DLK_BIT = 6;
endpackage

// File: rtl/dbg_pwr_access.sv
module dbg_pwr_access
  import dbg_pwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h310,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h314
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pwr_ack_i,
  input  logic              dlk_i,
  output rgn_e              rgn_o,
  output logic              acc_ok_o,
  output logic              prot_sel_o,
  output logic              prot_we_o,
  output logic              deny_o
);
  always_comb begin
    if (addr_i == CTRL_OFS)      rgn_o = RGN_CTRL;
    else if (addr_i == STAT_OFS) rgn_o = RGN_STAT;
    else                         rgn_o = RGN_PROT;
  end

  assign acc_ok_o   = pwr_ack_i & ~dlk_i;
  assign prot_sel_o = req_i & (rgn_o == RGN_PROT) & acc_ok_o;
  assign prot_we_o  = prot_sel_o & we_i;
  assign deny_o     = req_i & (rgn_o == RGN_PROT) & ~acc_ok_o;
endmodule

// File: rtl/dbg_pwr_ctrl_reg.sv
module dbg_pwr_ctrl_reg
  import dbg_pwr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              core_pd_req_i,
  output logic              pur_o,
  output logic              npd_o,
  output logic              pd_allow_o,
  output logic              pd_emul_o
);
  logic pur_q, npd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pur_q <= 1'b0;
      npd_q <= 1'b0;
    end else if (wr_en_i) begin
      pur_q <= wdata_i[PUR_BIT];
      npd_q <= wdata_i[NPD_BIT];
    end
  end

  assign pur_o      = pur_q;
  assign npd_o      = npd_q;
  // keep-powered turns a core powerdown into an emulated one
  assign pd_allow_o = core_pd_req_i & ~npd_q;
  assign pd_emul_o  = core_pd_req_i & npd_q;
endmodule

// File: rtl/dbg_pwr_rsp.sv
module dbg_pwr_rsp
  import dbg_pwr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  rgn_e              rgn_i,
  input  logic              deny_i,
  input  logic [DATA_W-1:0] ctrl_val_i,
  input  logic [DATA_W-1:0] stat_val_i,
  input  logic [DATA_W-1:0] prot_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  logic [DATA_W-1:0] rd_d, rd_q;
  logic              err_q;

  always_comb begin
    rd_d = '0;
    if (req_i && !we_i && !deny_i) begin
      unique case (rgn_i)
        RGN_CTRL: rd_d = ctrl_val_i;
        RGN_STAT: rd_d = stat_val_i;
        default:  rd_d = prot_rdata_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      err_q <= deny_i;
    end
  end

  assign rdata_o = rd_q;
  assign err_o   = err_q;
endmodule

// File: rtl/dbg_pwr_ctl.sv
module dbg_pwr_ctl
  import dbg_pwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h310,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h314
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              prot_sel_o,
  output logic              prot_we_o,
  input  logic [DATA_W-1:0] prot_rdata_i,
  output logic              pwrup_req_o,
  output logic              nopd_req_o,
  input  logic              pwr_ack_i,
  input  logic              dlk_i,
  input  logic              core_pd_req_i,
  output logic              pd_allow_o,
  output logic              pd_emul_o,
  output logic              acc_ok_o
);
  rgn_e              rgn;
  logic              deny;
  logic              ctrl_wr;
  logic [DATA_W-1:0] ctrl_val, stat_val;

  dbg_pwr_access #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
  ) u_access (
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .pwr_ack_i  (pwr_ack_i),
    .dlk_i      (dlk_i),
    .rgn_o      (rgn),
    .acc_ok_o   (acc_ok_o),
    .prot_sel_o (prot_sel_o),
    .prot_we_o  (prot_we_o),
    .deny_o     (deny)
  );

  assign ctrl_wr = req_i & we_i & (rgn == RGN_CTRL);

  dbg_pwr_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (ctrl_wr),
    .wdata_i       (wdata_i),
    .core_pd_req_i (core_pd_req_i),
    .pur_o         (pwrup_req_o),
    .npd_o         (nopd_req_o),
    .pd_allow_o    (pd_allow_o),
    .pd_emul_o     (pd_emul_o)
  );

  always_comb begin
    ctrl_val          = '0;
    ctrl_val[PUR_BIT] = pwrup_req_o;
    ctrl_val[NPD_BIT] = nopd_req_o;
    stat_val          = '0;
    stat_val[PU_BIT]  = pwr_ack_i;  // live, never latched
    stat_val[DLK_BIT] = dlk_i;
  end

  dbg_pwr_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (we_i),
    .rgn_i        (rgn),
    .deny_i       (deny),
    .ctrl_val_i   (ctrl_val),
    .stat_val_i   (stat_val),
    .prot_rdata_i (prot_rdata_i),
    .rdata_o      (rdata_o),
    .err_o        (err_o)
  );
endmodule

// File: rtl/dbg_pwr_ctl_chk.sv
module dbg_pwr_ctl_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h310,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h314
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              prot_sel_o,
  input logic              pwrup_req_o,
  input logic              nopd_req_o,
  input logic              pwr_ack_i,
  input logic              dlk_i,
  input logic              pd_allow_o,
  input logic              pd_emul_o,
  input logic              acc_ok_o
);
  logic ctrl_wr, stat_rd, prot_acc;
  assign ctrl_wr  = req_i && we_i && addr_i == CTRL_OFS;
  assign stat_rd  = req_i && !we_i && addr_i == STAT_OFS;
  assign prot_acc = req_i && addr_i != CTRL_OFS && addr_i != STAT_OFS;

  AST_WR_LOADS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (pwrup_req_o == $past(wdata_i[3])) && (nopd_req_o == $past(wdata_i[0]))); // R2
  AST_REQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(pwrup_req_o) && $stable(nopd_req_o)); // R2
  AST_STAT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> (rdata_o[0] == $past(pwr_ack_i)) && (rdata_o[6] == $past(dlk_i)) && !err_o); // R4
  AST_NO_SEL_DENIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlk_i || !pwr_ack_i) |-> !prot_sel_o && !acc_ok_o); // R5
  AST_DENY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_acc && !acc_ok_o) |=> err_o && rdata_o == '0); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !err_o && rdata_o == '0); // R11
  AST_PD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pd_allow_o && pd_emul_o)); // R9
  AST_PD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nopd_req_o |-> !pd_allow_o); // R9
endmodule

bind dbg_pwr_ctl dbg_pwr_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .err_o       (err_o),
  .prot_sel_o  (prot_sel_o),
  .pwrup_req_o (pwrup_req_o),
  .nopd_req_o  (nopd_req_o),
  .pwr_ack_i   (pwr_ack_i),
  .dlk_i       (dlk_i),
  .pd_allow_o  (pd_allow_o),
  .pd_emul_o   (pd_emul_o),
  .acc_ok_o    (acc_ok_o)
);

// File: tb/sim_dbg_pwr_ctl.sv
module sim_dbg_pwr_ctl;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [11:0] CTRL = 12'h310;
  localparam logic [11:0] STAT = 12'h314;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 0, we = 0, ack = 0, dlk = 0, cpd = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, prd = '0;
  logic [31:0] rdata;
  logic        err, psel, pwe, pur, npd, pda, pde, aok;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  bit          m_pur = 0, m_npd = 0;
  logic [31:0] e_rd = '0;
  bit          e_err = 0;
  string       e_tag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_pwr_ctl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .prot_sel_o(psel),
    .prot_we_o(pwe), .prot_rdata_i(prd), .pwrup_req_o(pur), .nopd_req_o(npd),
    .pwr_ack_i(ack), .dlk_i(dlk), .core_pd_req_i(cpd), .pd_allow_o(pda),
    .pd_emul_o(pde), .acc_ok_o(aok)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // model: computed from the inputs held at the edge
  always @(posedge clk) begin
    if (rst_ni) begin
      bit ok;
      ok = ack && !dlk;
      e_rd = '0; e_err = 0; e_tag = "R11";
      if (req) begin
        if (addr == CTRL) begin
          e_tag = ok ? "R3" : "R10";
          if (we) begin m_pur = wdata[3]; m_npd = wdata[0]; end
          else e_rd = {28'd0, m_pur, 2'b00, m_npd};
        end else if (addr == STAT) begin
          e_tag = we ? "R8" : (ok ? "R4" : "R10");
          if (!we) e_rd = {25'd0, dlk, 5'd0, ack};
        end else if (ok) begin
          e_tag = "R6";
          if (!we) e_rd = prd;
        end else begin
          e_tag = "R7"; e_err = 1;
        end
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      bit ok, pacc;
      ok   = ack && !dlk;
      pacc = req && addr != CTRL && addr != STAT;
      chk(rdata === e_rd, e_tag, rdata, e_rd);
      chk(err === e_err, e_tag, {31'd0, err}, {31'd0, e_err});
      chk(pur === m_pur, "R2", {31'd0, pur}, {31'd0, m_pur});
      chk(npd === m_npd, "R2", {31'd0, npd}, {31'd0, m_npd});
      chk(aok === ok, "R5", {31'd0, aok}, {31'd0, ok});
      chk(psel === (pacc && ok), pacc ? (ok ? "R6" : "R7") : "R6",
          {31'd0, psel}, {31'd0, pacc && ok});
      chk(pwe === (pacc && ok && we), "R6", {31'd0, pwe}, {31'd0, pacc && ok && we});
      chk(pda === (cpd && !m_npd), "R9", {31'd0, pda}, {31'd0, cpd && !m_npd});
      chk(pde === (cpd && m_npd), "R9", {31'd0, pde}, {31'd0, cpd && m_npd});
    end
  end

  task automatic acc(input bit w, input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req = 1; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0; addr = '0; wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*3);
    // R1: outputs during reset
    chk(pur === 0 && npd === 0, "R1", {30'd0, pur, npd}, 0);
    chk(rdata === 0 && err === 0, "R1", rdata, 0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    chk(pur === 0 && npd === 0 && rdata === 0 && err === 0, "R1", rdata, 0);

    // powered off: status, denied access, control access still served
    acc(0, STAT, 0);
    acc(0, 12'h0A0, 0);
    acc(1, 12'h0A4, 32'h1234);
    acc(1, CTRL, 32'h8);
    acc(0, CTRL, 0);
    idle(2);
    ack = 1;
    acc(0, STAT, 0);
    prd = 32'hA5A5_5A5A;
    acc(0, 12'h0A0, 0);
    acc(1, 12'h0A8, 32'hFFFF);
    acc(1, CTRL, 32'h9);
    cpd = 1; idle(2);
    acc(1, CTRL, 32'h8);
    idle(1);
    cpd = 0;
    dlk = 1;
    acc(0, 12'h0AC, 0);
    acc(0, CTRL, 0);
    acc(1, STAT, 32'hFFFF_FFFF);
    acc(0, STAT, 0);
    dlk = 0;
    acc(1, STAT, 32'h0000_0040);
    acc(0, STAT, 0);
    ack = 0;
    acc(0, STAT, 0);
    acc(1, CTRL, 32'hFFFF_FFF6);
    acc(0, CTRL, 0);
    ack = 1;
    // back-to-back protected reads
    @(posedge clk); #1; req = 1; we = 0; addr = 12'h0A0; prd = 32'h1111_0001;
    @(posedge clk); #1; prd = 32'h2222_0002;
    @(posedge clk); #1; dlk = 1;
    @(posedge clk); #1; req = 0; dlk = 0;
    idle(2);

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      int sel;
      @(posedge clk); #1;
      sel = $urandom_range(0, 3);
      req   = $urandom_range(0, 1);
      we    = $urandom_range(0, 1);
      addr  = (sel == 0) ? CTRL : (sel == 1) ? STAT : 12'($urandom_range(0, 4095));
      wdata = $urandom;
      prd   = $urandom;
      ack   = $urandom_range(0, 3) != 0;
      dlk   = $urandom_range(0, 4) == 0;
      cpd   = $urandom_range(0, 1);
    end
    @(posedge clk); #1; req = 0;
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule